// File: doc/BRIEF.md
# Multicast Replication Stage

This block sits on each node of a three-dimensional torus. It copies one packet to several outputs. A multicast packet, whether injected by a local client or arriving over a link, carries a pattern number. The pattern number indexes a programmable table. Each table entry is a port mask covering the six outgoing torus links and the seven local destination memories. The block then presents the packet once to every port named in the mask. It serves one port at a time and waits on each port's ready signal. Only after the last copy is taken does it accept the next packet.

A unicast packet does not use the table. It carries an output port index, already computed upstream, and leaves through that single port. A configuration write port loads table entries at any time. An entry of all zeros, or a unicast index that names no port, discards the packet and sets a sticky error flag.

The output ports share one data bus and have separate valid and ready bits. Port numbering is fixed: mask bits 0 to 5 are the links +X, -X, +Y, -Y, +Z, -Z. Bits 6 to 12 are the local memories: four processing slices, the interaction unit, then two accumulation memories.

Top module: `mfwd_fanout`

## Requirements
- R1: After reset, in_ready is 1, out_valid is all zeros, drop_err is 0 and every table entry is empty.
- R2: A multicast packet is copied exactly to the ports whose bits are set in the table entry selected by in_pattern. Mask bits 0..5 are link ports and bits 6..12 are local client ports.
- R3: At most one out_valid bit is high at any time. Copies of a packet go out in ascending port number, and each accepted copy moves to the next selected port on the following cycle.
- R4: While the active port's out_ready is low, that out_valid bit and out_data stay unchanged. Ready on any other port has no effect.
- R5: in_ready is low while any copy of the current packet is outstanding. It returns high in the cycle after the last copy is accepted.
- R6: A unicast packet (in_mcast = 0) produces one copy on port in_port, and the table is not consulted.
- R7: A multicast packet whose entry is all zeros, or a unicast packet with in_port of 13 or more, produces no copy and sets drop_err. drop_err stays set until reset.
- R8: A table write to the entry being replicated does not change the packet in flight; the next packet that uses that entry sees the new mask.
- R9: A table write and a lookup of the same entry in the same cycle give the lookup the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Stage can take a new packet |
| in_mcast | input | 1 | 1 = multicast (table lookup), 0 = unicast |
| in_pattern | input | PAT_W | Table index for a multicast packet |
| in_port | input | 4 | Output port for a unicast packet |
| in_data | input | DATA_W | Packet payload word |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | PAT_W | Table entry to write |
| cfg_mask | input | 13 | Port mask to store |
| out_valid | output | 13 | Per-port copy valid |
| out_ready | input | 13 | Per-port copy ready |
| out_data | output | DATA_W | Payload for the port being served |
| drop_err | output | 1 | Sticky flag: a packet had no destination |

## Verification
The embedded properties watch four things on every cycle: at most one port is offered a copy, the port order only climbs within a packet, a stalled copy holds its data, and the input stays closed while copies are outstanding. The same properties also check that the drop flag never clears, that a dropped packet offers no copy, and that a unicast packet offers exactly one copy. Only the bench's scenarios can show the other points. These are that the copies match the programmed entry, that ready on a port other than the active one is ignored, and that a table write affects only later packets, including a write and lookup in the same cycle. The bench keeps its own table and pending-port model and compares ready, valid, data and the error flag against it every cycle.

// File: rtl/mfwd_pkg.sv
package mfwd_pkg;
  localparam int LINK_PORTS   = 6;
  localparam int CLIENT_PORTS = 7;
  localparam int PORTS        = LINK_PORTS + CLIENT_PORTS;
  localparam int PORT_IDX_W   = $clog2(PORTS);

  typedef logic [PORTS-1:0] port_mask_t;

  // Isolate the lowest set bit: the next port to serve.
  function automatic port_mask_t first_port(port_mask_t m);
    return m & (~m + PORTS'(1));
  endfunction

  // One-hot mask for a unicast port index; empty when out of range.
  function automatic port_mask_t port_to_mask(logic [PORT_IDX_W-1:0] idx);
    port_mask_t r;
    for (int i = 0; i < PORTS; i++) r[i] = (idx == PORT_IDX_W'(i));
    return r;
  endfunction
endpackage

// File: rtl/mfwd_table.sv
module mfwd_table
  import mfwd_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  port_mask_t       wr_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output port_mask_t       rd_mask
);
  localparam int ENTRIES = 1 << IDX_W;

  port_mask_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_mask;
    end
  end

  // Read is combinational, so a same-cycle write is seen only afterwards (R9).
  assign rd_mask = mem[rd_idx];

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_mask)));
endmodule

// File: rtl/mfwd_seq.sv
module mfwd_seq
  import mfwd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  port_mask_t        take_mask,
  input  logic [DATA_W-1:0] take_data,
  output logic              busy,
  output port_mask_t        out_valid,
  input  port_mask_t        out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              drop_err
);
  port_mask_t        pending;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  // Named events for the properties.
  port_mask_t cur_port;
  port_mask_t remaining;
  logic       copy_done;
  logic       drop_evt;

  assign cur_port  = first_port(pending);
  assign remaining = pending & ~cur_port;
  assign copy_done = |(cur_port & out_ready);
  assign drop_evt  = take && (take_mask == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (take) begin
        if (drop_evt) begin
          err_q <= 1'b1;
        end else begin
          pending <= take_mask;
          data_q  <= take_data;
        end
      end else if (copy_done) begin
        pending <= remaining;
      end
    end
  end

  assign busy      = |pending;
  assign out_valid = cur_port;
  assign out_data  = data_q;
  assign drop_err  = err_q;

  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && (remaining != '0)) |=> (out_valid > $past(out_valid)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_data)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err);

  a_r7_drop_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (out_valid == '0));
endmodule

// File: rtl/mfwd_fanout.sv
module mfwd_fanout
  import mfwd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PAT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_mcast,
  input  logic [PAT_W-1:0]      in_pattern,
  input  logic [PORT_IDX_W-1:0] in_port,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  cfg_we,
  input  logic [PAT_W-1:0]      cfg_idx,
  input  logic [PORTS-1:0]      cfg_mask,
  output logic [PORTS-1:0]      out_valid,
  input  logic [PORTS-1:0]      out_ready,
  output logic [DATA_W-1:0]     out_data,
  output logic                  drop_err
);
  port_mask_t tbl_mask;
  port_mask_t sel_mask;
  logic       busy;
  logic       take;

  mfwd_table #(.IDX_W(PAT_W)) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_mask (cfg_mask),
    .rd_idx  (in_pattern),
    .rd_mask (tbl_mask)
  );

  assign in_ready = ~busy;
  assign take     = in_valid && in_ready;
  assign sel_mask = in_mcast ? tbl_mask : port_to_mask(in_port);

  mfwd_seq #(.DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_mask (sel_mask),
    .take_data (in_data),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .drop_err  (drop_err)
  );

  a_r5_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> !in_ready);

  a_r6_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_mcast && (in_port < PORT_IDX_W'(PORTS))) |=> ($countones(out_valid) == 1));
endmodule

// File: tb/mfwd_fanout_tb_top.sv
module mfwd_fanout_tb_top;
  localparam int NP = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mcast = 1'b0;
  logic [7:0]  in_pattern = '0;
  logic [3:0]  in_port = '0;
  logic [63:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic [12:0] cfg_mask = '0;
  logic [12:0] out_valid;
  logic [12:0] out_ready = '1;
  logic [63:0] out_data;
  logic        drop_err;

  always #5 clk = ~clk;

  mfwd_fanout dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcast(in_mcast), .in_pattern(in_pattern), .in_port(in_port),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .drop_err(drop_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: table, pending set of ports, held data, flag.
  logic [12:0] m_tbl [256];
  logic [12:0] m_pend;
  logic [63:0] m_data;
  logic        m_err;

  function automatic logic [12:0] lowest(logic [12:0] m);
    for (int i = 0; i < NP; i++) if (m[i]) return 13'(1) << i;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_tbl[i] = '0;
      m_pend = '0;
      m_data = '0;
      m_err  = 1'b0;
    end else begin
      logic [12:0] want;
      logic [12:0] head;
      head = lowest(m_pend);
      if (m_pend == '0 && in_valid) begin
        if (in_mcast) want = m_tbl[in_pattern];
        else want = (in_port < 4'd13) ? (13'(1) << in_port) : 13'd0;
        if (want == '0) m_err = 1'b1;
        else begin
          m_pend = want;
          m_data = in_data;
        end
      end else if ((head & out_ready) != '0) begin
        m_pend = m_pend & ~head;
      end
      if (cfg_we) m_tbl[cfg_idx] = cfg_mask;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 in_ready vs model", 64'(in_ready), 64'(m_pend == '0));
      chk("R2/R3 out_valid vs model", 64'(out_valid), 64'(lowest(m_pend)));
      chk("R7 drop_err vs model", 64'(drop_err), 64'(m_err));
      if (m_pend != '0) chk("R4 out_data vs model", out_data, m_data);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic cfg_write(logic [7:0] idx, logic [12:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Returns at the negedge after the accepting edge.
  task automatic send(logic mc, logic [7:0] pat, logic [3:0] port, logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_mcast = mc; in_pattern = pat; in_port = port; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_copy(string tag, logic [12:0] exp);
    chk(tag, 64'(out_valid), 64'(exp));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 drop_err after reset", 64'(drop_err), 64'd0);

    // R2 / R3: links 0,2,5 and a local client at bit 12, served in ascending order.
    cfg_write(8'd5, 13'h1025);
    send(1'b1, 8'd5, 4'd0, 64'hA5A5_0001);
    expect_copy("R3 copy port 0", 13'h0001);
    expect_copy("R3 copy port 2", 13'h0004);
    expect_copy("R3 copy port 5", 13'h0020);
    expect_copy("R2 copy client port 12", 13'h1000);
    chk("R5 in_ready after last copy", 64'(in_ready), 64'd1);
    chk("R2 no stray copy", 64'(out_valid), 64'd0);

    // R4 / R5: backpressure on port 1 of entry {1,8}.
    cfg_write(8'd9, 13'h0102);
    out_ready = '0;
    send(1'b1, 8'd9, 4'd0, 64'hBEEF_0002);
    chk("R4 first copy port 1", 64'(out_valid), 64'h2);
    chk("R5 in_ready low while busy", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk("R4 copy held", 64'(out_valid), 64'h2);
    chk("R4 data held", out_data, 64'hBEEF_0002);
    out_ready = 13'h0100;
    @(negedge clk);
    chk("R4 other-port ready ignored", 64'(out_valid), 64'h2);
    out_ready = '1;
    @(negedge clk);
    chk("R4 advance after ready", 64'(out_valid), 64'h100);
    @(negedge clk);
    chk("R5 reopens after last copy", 64'(in_ready), 64'd1);

    // R6: unicast to port 10, pattern field points at a populated entry.
    send(1'b0, 8'd5, 4'd10, 64'hC0DE_0003);
    expect_copy("R6 unicast single copy", 13'h0400);
    chk("R6 no further copy", 64'(out_valid), 64'd0);

    // R7: empty entry and out-of-range unicast index.
    send(1'b1, 8'd77, 4'd0, 64'hDEAD_0004);
    chk("R7 empty entry no copy", 64'(out_valid), 64'd0);
    chk("R7 empty entry flag", 64'(drop_err), 64'd1);
    chk("R7 input stays open", 64'(in_ready), 64'd1);
    send(1'b0, 8'd0, 4'd14, 64'hDEAD_0005);
    chk("R7 bad unicast no copy", 64'(out_valid), 64'd0);

    // R8: rewrite entry 5 while its packet is in flight.
    out_ready = '0;
    send(1'b1, 8'd5, 4'd0, 64'h1234_0006);
    cfg_write(8'd5, 13'h0008);
    out_ready = '1;
    expect_copy("R8 in-flight keeps port 0", 13'h0001);
    expect_copy("R8 in-flight keeps port 2", 13'h0004);
    expect_copy("R8 in-flight keeps port 5", 13'h0020);
    expect_copy("R8 in-flight keeps port 12", 13'h1000);
    send(1'b1, 8'd5, 4'd0, 64'h1234_0007);
    expect_copy("R8 next packet uses new mask", 13'h0008);
    chk("R7 flag still set", 64'(drop_err), 64'd1);

    // R9: write and lookup of entry 5 in the same cycle.
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'd5; cfg_mask = 13'h0010;
    in_valid = 1'b1; in_mcast = 1'b1; in_pattern = 8'd5; in_data = 64'h5555_0008;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    expect_copy("R9 same-cycle lookup sees old mask", 13'h0008);
    send(1'b1, 8'd5, 4'd0, 64'h5555_0009);
    expect_copy("R9 later lookup sees new mask", 13'h0010);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule